// File: doc/BRIEF.md
# Self-Clearing Module Reset Controller

This block sequences resets inside a multi-port network device. Host software starts a global soft reset or a reset of one PHY by writing a command bit. The block drives the matching reset outputs for a fixed number of clock cycles. When the interval ends, it clears the command bit, so software can poll the bit until it reads zero. Each PHY can also be reset when it leaves power-down. That path restarts the PHY but leaves its registers alone.

The soft reset runs in two phases. First it holds the host bus interface, the host MAC and the low system registers in reset. The host MAC reset also clears its latched transmit and receive error flags. Then the block asks the configuration loader to load the MAC address and nothing else. The length of this load phase depends on the kind of EEPROM fitted. The soft reset does not sample the configuration straps, and it does not touch the PHYs.

The soft-reset sequencer has three states. In IDLE, a request moves it to HOLD. In HOLD, when the count ends, it moves to LOAD if the EEPROM kind needs extra time, otherwise back to IDLE. In LOAD, when the count ends, it returns to IDLE.

Each port has its own PHY sequencer with three states. In IDLE, a request moves it to RUN, or to WAIT if a soft reset is active or starting. WAIT moves to RUN once the soft reset has finished. RUN returns to IDLE when its count ends.

All durations are parameters in microseconds, converted to clock cycles from the clock-frequency parameter.

Top module: `modrst_ctrl`

## Requirements
- R1: A pulse on `soft_req` while the soft reset is idle sets `soft_busy` high from the next cycle. It stays high for exactly BASE+EXTRA cycles and then clears by itself. BASE is the base soft-reset length in cycles; EXTRA is the load-phase length.
- R2: `soft_dom_rst` is high for exactly the first BASE cycles of a soft reset. A soft reset never raises any `phy_rst` bit.
- R3: After the hold phase, `mac_load_req` is high for EXTRA cycles and never overlaps `soft_dom_rst`. EXTRA is set by `eep_kind` as sampled at the request: 0 means no EEPROM (0 cycles), 1 means I2C (I2C cycles), 2 means Microwire (MW cycles), and 3 means no EEPROM.
- R4: A pulse on bit n of `phy_ctl_req` starts a reset of port n. `phy_rst[n]`, `phy_reg_rst[n]` and `phy_bit[n]` are each high for exactly PHY cycles. `phy_nasr_keep[n]` stays low. The soft outputs and `mac_load_req` stay low.
- R5: A pulse on bit n of `phy_bcr_req` acts as in R4, except that `phy_nasr_keep[n]` is high for the whole reset.
- R6: A pulse on bit n of `phy_pd_exit` raises `phy_rst[n]` for PHY cycles. `phy_reg_rst[n]` and `phy_bit[n]` stay low.
- R7: A further request to a soft reset or PHY reset that is already in progress is ignored. The reset is not extended, and its source does not change.
- R8: A PHY request that arrives with or during a soft reset is held. `phy_bit` reads high while it waits. `phy_rst` rises only after `soft_busy` has been low for one cycle.
- R9: Each port's PHY reset runs on its own counter. Overlapping resets on different ports each last PHY cycles.
- R10: If several sources hit the same port in one cycle, the control-register bit wins over the basic-control bit, which wins over power-down exit.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_req | input | 1 | One-cycle write of 1 to the soft-reset bit |
| eep_kind | input | 2 | EEPROM kind: 0 none, 1 I2C, 2 Microwire, 3 none |
| phy_ctl_req | input | NPORT | Per-port write of 1 to the reset-control PHY bit |
| phy_bcr_req | input | NPORT | Per-port write of 1 to the PHY basic-control reset bit |
| phy_pd_exit | input | NPORT | Per-port pulse when the PHY leaves power-down |
| soft_busy | output | 1 | Soft-reset bit readback, self-clearing |
| soft_dom_rst | output | 1 | Reset of host bus interface, host MAC (clears its error flags) and low system registers |
| mac_load_req | output | 1 | Request to the loader to load the MAC address only |
| phy_rst | output | NPORT | Per-port PHY module reset |
| phy_reg_rst | output | NPORT | Per-port PHY register-file reset |
| phy_nasr_keep | output | NPORT | Per-port signal to preserve register bits not affected by soft reset |
| phy_bit | output | NPORT | Per-port PHY reset bit readback, self-clearing |

## Verification
The assertions assume that every request input is a single-cycle write pulse. They also assume that `eep_kind` matters only in the cycle of a soft request, and that all parameters give at least one cycle of PHY and base time.

The bench drives every request for exactly one cycle, from the falling edge. It holds `eep_kind` steady across each whole soft-reset run. It lets each scenario drain to idle before the next one begins, so that no property sees a reset that started before the scenario.

// File: rtl/modrst_pkg.sv
`timescale 1ns/1ps
package modrst_pkg;
    typedef enum logic [1:0] {SOFT_IDLE, SOFT_HOLD, SOFT_LOAD} soft_st_t;
    typedef enum logic [1:0] {PHY_IDLE, PHY_WAIT, PHY_RUN} phy_st_t;
    typedef enum logic [1:0] {SRC_CTL, SRC_BCR, SRC_PD} phy_src_t;

    localparam logic [1:0] EEP_I2C = 2'd1;
    localparam logic [1:0] EEP_MW  = 2'd2;

    function automatic int us_to_cyc(input int mhz, input int us);
        return mhz * us;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/modrst_soft_seq.sv
`timescale 1ns/1ps
module modrst_soft_seq
    import modrst_pkg::*;
#(
    parameter int BASE_CYC = 8,
    parameter int I2C_CYC  = 5,
    parameter int MW_CYC   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] eep_kind,
    output logic       busy,
    output logic       dom_rst,
    output logic       load_req
);
    localparam int MAXC  = max3(BASE_CYC, I2C_CYC, MW_CYC);
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    soft_st_t         state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]       eep_q, eep_n;
    int               extra;

    always_comb begin
        case (eep_q)
            EEP_I2C: extra = I2C_CYC;
            EEP_MW:  extra = MW_CYC;
            default: extra = 0;
        endcase
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        eep_n   = eep_q;
        unique case (state)
            SOFT_IDLE: begin
                if (start) begin
                    state_n = SOFT_HOLD;
                    cnt_n   = CNT_W'(BASE_CYC - 1);
                    eep_n   = eep_kind;
                end
            end
            SOFT_HOLD: begin
                if (cnt == '0) begin
                    if (extra == 0) begin
                        state_n = SOFT_IDLE;
                    end else begin
                        state_n = SOFT_LOAD;
                        cnt_n   = CNT_W'(extra - 1);
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            SOFT_LOAD: begin
                if (cnt == '0) state_n = SOFT_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = SOFT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SOFT_IDLE;
            cnt   <= '0;
            eep_q <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            eep_q <= eep_n;
        end
    end

    always_comb begin
        busy     = (state != SOFT_IDLE);
        dom_rst  = (state == SOFT_HOLD);
        load_req = (state == SOFT_LOAD);
    end
endmodule

// File: rtl/modrst_phy_seq.sv
`timescale 1ns/1ps
module modrst_phy_seq
    import modrst_pkg::*;
#(
    parameter int PHY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_ctl,
    input  logic req_bcr,
    input  logic req_pd,
    input  logic soft_hold,
    output logic rst_out,
    output logic reg_rst,
    output logic nasr_keep,
    output logic bit_rd
);
    localparam int CNT_W = (PHY_CYC < 2) ? 1 : $clog2(PHY_CYC + 1);

    phy_st_t          state, state_n;
    phy_src_t         src, src_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        src_n   = src;
        cnt_n   = cnt;
        unique case (state)
            PHY_IDLE: begin
                if (req_ctl || req_bcr || req_pd) begin
                    src_n = req_ctl ? SRC_CTL : (req_bcr ? SRC_BCR : SRC_PD);
                    if (soft_hold) begin
                        state_n = PHY_WAIT;
                    end else begin
                        state_n = PHY_RUN;
                        cnt_n   = CNT_W'(PHY_CYC - 1);
                    end
                end
            end
            PHY_WAIT: begin
                if (!soft_hold) begin
                    state_n = PHY_RUN;
                    cnt_n   = CNT_W'(PHY_CYC - 1);
                end
            end
            PHY_RUN: begin
                if (cnt == '0) state_n = PHY_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = PHY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PHY_IDLE;
            src   <= SRC_PD;
            cnt   <= '0;
        end else begin
            state <= state_n;
            src   <= src_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        rst_out   = (state == PHY_RUN);
        reg_rst   = (state == PHY_RUN) && (src != SRC_PD);
        nasr_keep = (state == PHY_RUN) && (src == SRC_BCR);
        bit_rd    = (state != PHY_IDLE) && (src != SRC_PD);
    end
endmodule

// File: rtl/modrst_ctrl.sv
`timescale 1ns/1ps
module modrst_ctrl
    import modrst_pkg::*;
#(
    parameter int NPORT    = 2,
    parameter int CLK_MHZ  = 125,
    parameter int SOFT_US  = 590,
    parameter int I2C_US   = 550,
    parameter int MW_US    = 170,
    parameter int PHY_US   = 110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_req,
    input  logic [1:0]       eep_kind,
    input  logic [NPORT-1:0] phy_ctl_req,
    input  logic [NPORT-1:0] phy_bcr_req,
    input  logic [NPORT-1:0] phy_pd_exit,
    output logic             soft_busy,
    output logic             soft_dom_rst,
    output logic             mac_load_req,
    output logic [NPORT-1:0] phy_rst,
    output logic [NPORT-1:0] phy_reg_rst,
    output logic [NPORT-1:0] phy_nasr_keep,
    output logic [NPORT-1:0] phy_bit
);
    localparam int BASE_CYC = us_to_cyc(CLK_MHZ, SOFT_US);
    localparam int I2C_CYC  = us_to_cyc(CLK_MHZ, I2C_US);
    localparam int MW_CYC   = us_to_cyc(CLK_MHZ, MW_US);
    localparam int PHY_CYC  = us_to_cyc(CLK_MHZ, PHY_US);

    logic soft_hold;

    modrst_soft_seq #(
        .BASE_CYC(BASE_CYC),
        .I2C_CYC (I2C_CYC),
        .MW_CYC  (MW_CYC)
    ) soft_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (soft_req),
        .eep_kind(eep_kind),
        .busy    (soft_busy),
        .dom_rst (soft_dom_rst),
        .load_req(mac_load_req)
    );

    assign soft_hold = soft_busy | soft_req;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        modrst_phy_seq #(.PHY_CYC(PHY_CYC)) phy_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_ctl  (phy_ctl_req[p]),
            .req_bcr  (phy_bcr_req[p]),
            .req_pd   (phy_pd_exit[p]),
            .soft_hold(soft_hold),
            .rst_out  (phy_rst[p]),
            .reg_rst  (phy_reg_rst[p]),
            .nasr_keep(phy_nasr_keep[p]),
            .bit_rd   (phy_bit[p])
        );
    end
endmodule

// File: rtl/modrst_ctrl_chk.sv
`timescale 1ns/1ps
module modrst_ctrl_chk #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_busy,
    input logic             soft_dom_rst,
    input logic             mac_load_req,
    input logic [NPORT-1:0] phy_rst,
    input logic [NPORT-1:0] phy_reg_rst,
    input logic [NPORT-1:0] phy_nasr_keep,
    input logic [NPORT-1:0] phy_bit
);
    assert_dom_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_dom_rst |-> soft_busy);

    assert_load_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mac_load_req |-> (soft_busy && !soft_dom_rst));

    assert_busy_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_busy) |-> (!soft_dom_rst && !mac_load_req));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        assert_regrst_in_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
            phy_reg_rst[p] |-> (phy_rst[p] && phy_bit[p]));

        assert_nasr_with_regrst_R5: assert property (@(posedge clk) disable iff (!rst_n)
            phy_nasr_keep[p] |-> phy_reg_rst[p]);

        assert_phy_after_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(phy_rst[p]) |-> !$past(soft_busy));
    end
endmodule

bind modrst_ctrl modrst_ctrl_chk #(.NPORT(NPORT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_busy    (soft_busy),
    .soft_dom_rst (soft_dom_rst),
    .mac_load_req (mac_load_req),
    .phy_rst      (phy_rst),
    .phy_reg_rst  (phy_reg_rst),
    .phy_nasr_keep(phy_nasr_keep),
    .phy_bit      (phy_bit)
);

// File: tb/modrst_ctrl_tb_top.sv
`timescale 1ns/1ps
module modrst_ctrl_tb_top;
    localparam int NP = 2;
    localparam int WIN = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_req = 1'b0;
    logic [1:0]    eep_kind = 2'd0;
    logic [NP-1:0] ctl = '0, bcr = '0, pd = '0;
    logic          soft_busy, soft_dom_rst, mac_load_req;
    logic [NP-1:0] phy_rst, phy_reg_rst, phy_nasr_keep, phy_bit;

    int n_tests = 0;
    int n_fail  = 0;
    int c_busy, c_dom, c_load, c_ovl;
    int c_rst [NP];
    int c_reg [NP];
    int c_nasr[NP];
    int c_bit [NP];

    always #4 clk = ~clk;

    modrst_ctrl #(
        .NPORT(NP), .CLK_MHZ(1), .SOFT_US(8), .I2C_US(5), .MW_US(3), .PHY_US(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_req(soft_req), .eep_kind(eep_kind),
        .phy_ctl_req(ctl), .phy_bcr_req(bcr), .phy_pd_exit(pd),
        .soft_busy(soft_busy), .soft_dom_rst(soft_dom_rst), .mac_load_req(mac_load_req),
        .phy_rst(phy_rst), .phy_reg_rst(phy_reg_rst), .phy_nasr_keep(phy_nasr_keep),
        .phy_bit(phy_bit)
    );

    // mode: 0 soft, 1 control bit, 2 basic-control bit, 3 power-down exit
    typedef struct packed {
        logic [7:0] mode, port, eep, e_busy, e_dom, e_load, e_rst, e_reg, e_nasr, e_bit;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'd0, 8'd0, 8'd0,  8'd8, 8'd8, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd0, 8'd0, 8'd1, 8'd13, 8'd8, 8'd5, 8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd0, 8'd0, 8'd2, 8'd11, 8'd8, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd1, 8'd0, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd4, 8'd0, 8'd4},
        '{8'd1, 8'd1, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd4, 8'd0, 8'd4},
        '{8'd2, 8'd0, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd4, 8'd4, 8'd4},
        '{8'd2, 8'd1, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd4, 8'd4, 8'd4},
        '{8'd3, 8'd0, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd0, 8'd0, 8'd0},
        '{8'd3, 8'd1, 8'd0,  8'd0, 8'd0, 8'd0, 8'd4, 8'd0, 8'd0, 8'd0}
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clr_counts();
        c_busy = 0; c_dom = 0; c_load = 0; c_ovl = 0;
        for (int p = 0; p < NP; p++) begin
            c_rst[p] = 0; c_reg[p] = 0; c_nasr[p] = 0; c_bit[p] = 0;
        end
    endtask

    // drive at falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic s, input logic [NP-1:0] c, input logic [NP-1:0] b,
                        input logic [NP-1:0] d);
        soft_req = s; ctl = c; bcr = b; pd = d;
        @(posedge clk);
        @(negedge clk);
        soft_req = 1'b0; ctl = '0; bcr = '0; pd = '0;
        c_busy += int'(soft_busy);
        c_dom  += int'(soft_dom_rst);
        c_load += int'(mac_load_req);
        c_ovl  += int'(soft_busy && (phy_rst != '0));
        for (int p = 0; p < NP; p++) begin
            c_rst[p]  += int'(phy_rst[p]);
            c_reg[p]  += int'(phy_reg_rst[p]);
            c_nasr[p] += int'(phy_nasr_keep[p]);
            c_bit[p]  += int'(phy_bit[p]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs low during reset
        chk("R11 reset soft outputs", int'({soft_busy, soft_dom_rst, mac_load_req}), 0);
        chk("R11 reset phy outputs", int'({phy_rst, phy_reg_rst, phy_nasr_keep, phy_bit}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            logic [NP-1:0] m;
            int pt;
            pt = int'(VECS[v].port);
            m = NP'(1) << pt;
            eep_kind = VECS[v].eep[1:0];
            clr_counts();
            unique case (VECS[v].mode)
                8'd0: step(1'b1, '0, '0, '0);
                8'd1: step(1'b0, m, '0, '0);
                8'd2: step(1'b0, '0, m, '0);
                default: step(1'b0, '0, '0, m);
            endcase
            idle(WIN - 1);
            // R1 R2 R3 soft lengths; R4 R5 R6 per-source PHY behaviour
            chk($sformatf("R1 vec%0d soft_busy cycles", v), c_busy, int'(VECS[v].e_busy));
            chk($sformatf("R2 vec%0d soft_dom_rst cycles", v), c_dom, int'(VECS[v].e_dom));
            chk($sformatf("R3 vec%0d mac_load_req cycles", v), c_load, int'(VECS[v].e_load));
            chk($sformatf("R4 vec%0d phy_rst cycles", v), c_rst[pt], int'(VECS[v].e_rst));
            chk($sformatf("R6 vec%0d phy_reg_rst cycles", v), c_reg[pt], int'(VECS[v].e_reg));
            chk($sformatf("R5 vec%0d phy_nasr_keep cycles", v), c_nasr[pt], int'(VECS[v].e_nasr));
            chk($sformatf("R4 vec%0d phy_bit cycles", v), c_bit[pt], int'(VECS[v].e_bit));
            chk($sformatf("R9 vec%0d other port untouched", v), c_rst[1 - pt], 0);
        end

        // R7: soft rewrite during hold does not extend
        eep_kind = 2'd0;
        clr_counts();
        step(1'b1, '0, '0, '0);
        idle(2);
        step(1'b1, '0, '0, '0);
        idle(WIN);
        chk("R7 soft rewrite busy cycles", c_busy, 8);
        chk("R7 soft rewrite dom cycles", c_dom, 8);

        // R7: PHY rewrite from another source neither extends nor changes source
        clr_counts();
        step(1'b0, 2'b01, '0, '0);
        idle(1);
        step(1'b0, '0, 2'b01, '0);
        idle(WIN);
        chk("R7 phy rewrite rst cycles", c_rst[0], 4);
        chk("R7 phy rewrite nasr cycles", c_nasr[0], 0);

        // R8: PHY request with soft request waits, bit reads set meanwhile
        clr_counts();
        step(1'b1, 2'b01, '0, '0);
        idle(WIN);
        chk("R8 no overlap of phy_rst and soft_busy", c_ovl, 0);
        chk("R8 deferred phy_rst cycles", c_rst[0], 4);
        chk("R8 phy_bit wait plus run cycles", c_bit[0], 13);

        // R9: overlapping resets on both ports
        clr_counts();
        step(1'b0, 2'b01, '0, '0);
        step(1'b0, '0, '0, 2'b10);
        idle(WIN);
        chk("R9 port0 rst cycles", c_rst[0], 4);
        chk("R9 port1 rst cycles", c_rst[1], 4);
        chk("R9 port1 reg_rst cycles", c_reg[1], 0);

        // R10: all sources at once on port 1 -> control-bit source
        clr_counts();
        step(1'b0, 2'b10, 2'b10, 2'b10);
        idle(WIN);
        chk("R10 reg_rst cycles", c_reg[1], 4);
        chk("R10 nasr cycles", c_nasr[1], 0);
        // R10: basic-control over power-down exit
        clr_counts();
        step(1'b0, '0, 2'b10, 2'b10);
        idle(WIN);
        chk("R10 bcr over pd nasr cycles", c_nasr[1], 4);

        // R11: asynchronous reset mid-sequence clears outputs
        step(1'b1, 2'b11, '0, '0);
        idle(2);
        rst_n = 1'b0;
        #1;
        chk("R11 mid-run reset outputs", int'({soft_busy, soft_dom_rst, mac_load_req,
            phy_rst, phy_reg_rst, phy_nasr_keep, phy_bit}), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule